// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit output of a CAN protocol controller and the enable of the line driver. The transmit line is active-low: low is dominant, high is recessive. The guard measures how long the line has been held dominant. If that run is longer than a timeout value programmed in clock cycles, the guard forces its output to the driver recessive and raises a timeout flag. A stuck controller or stuck software therefore cannot hold the bus dominant for good.

After a timeout the guard does not release by itself, however long the line stays low. It drives the output again only after it has sampled the transmit input high. The counter saturates, so a line held low forever cannot wrap the count and re-enable the driver. The raw input passes through a two-flop synchronizer and resets to recessive. An undriven pin has a pull-up on the board, so it reads recessive and never starts the timer.

The timeout sets the lowest usable bit rate. It has to be longer than the longest legal run of dominant bits at the slowest rate the bus uses, for example 10 kbit/s.

Top module: `txg_guard`

## Requirements
- R1: While reset is asserted and directly after it, tx_out is 1, to_flag is 0 and the dominant counter is cleared.
- R2: With no timeout pending, tx_out equals the value tx_in had three rising clock edges earlier: two synchronizer stages and one output register.
- R3: Suppose tx_in is first sampled low at edge k and stays low. Then tx_out is 0 after edges k+2 through k+1+T, where T is timeout_cyc. At edge k+2+T, to_flag becomes 1 and tx_out becomes 1.
- R4: Once to_flag is 1, it stays 1 and tx_out stays 1 for as long as the synchronized input stays low.
- R5: After a timeout, the first synchronized high sample clears to_flag at the next edge, and tx_out then follows tx_in again as in R2.
- R6: Any synchronized high sample clears the dominant counter. A new low run is given the full T cycles again.
- R7: The counter saturates at its all-ones value. With T set to all ones, a low run of any length still times out and the output stays recessive.
- R8: With T equal to 0, tx_out never goes dominant. to_flag rises at edge k+2 for a low first sampled at edge k.
- R9: An undriven transmit pin, pulled high, reads recessive. It never starts the timer or raises to_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in | input | 1 | Raw transmit line from the controller, low = dominant |
| timeout_cyc | input | CNT_W | Longest dominant run allowed, in clock cycles |
| tx_out | output | 1 | Gated transmit line to the driver |
| to_flag | output | 1 | High while a dominant timeout is in force |

## Verification
A low on tx_in reaches tx_out three rising edges later. A timeout appears on both outputs T+2 edges after the first low sample, and a release shows two edges after tx_in returns high. The bench keeps a behavioural model fed with the same pin value at every rising edge. The model holds a two-entry queue for the synchronizer delay and an unbounded integer for the run length, and the bench compares both outputs with it at every falling edge. That comparison puts each result on the exact edge where it is due. The stimulus changes only on falling edges, so no result depends on the order of processes at a clock edge.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef struct packed {
        logic stage1;
        logic stage2;
    } sync_st_t;

    typedef struct packed {
        logic flag;
        logic drv;
    } gate_st_t;

endpackage

// File: rtl/txg_sync.sv
module txg_sync
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    // R1: both stages reset to recessive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stage1: 1'b1, stage2: 1'b1};
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;
endmodule

// File: rtl/txg_timer.sv
module txg_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,
    input  logic [CNT_W-1:0] limit,
    output logic             trip
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_s)              st_d.cnt = '0;           // R6
        else if (st_q.cnt != SAT) st_d.cnt = st_q.cnt + 1'b1; // R7 saturate
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trip = !line_s && (st_q.cnt >= limit);

    a_r6_clear_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        line_s |=> (st_q.cnt == '0));
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_s && st_q.cnt == SAT) |=> (st_q.cnt == SAT));
endmodule

// File: rtl/txg_gate.sv
module txg_gate
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic trip,
    output logic flag,
    output logic drv
);
    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_s) st_d.flag = 1'b0;              // R5
        else        st_d.flag = st_q.flag | trip;  // R3, R4
        st_d.drv = line_s | st_d.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b0, drv: 1'b1};
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign drv  = st_q.drv;

    a_r4_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !line_s) |=> st_q.flag);
    a_r4_flag_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |-> st_q.drv);
    a_r5_release_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && line_s) |=> !st_q.flag);
    a_r3_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> st_q.flag);
endmodule

// File: rtl/txg_guard.sv
module txg_guard #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_in,
    input  logic [CNT_W-1:0] timeout_cyc,
    output logic             tx_out,
    output logic             to_flag
);
    logic line_s;
    logic trip;

    txg_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (tx_in),
        .sync_out (line_s)
    );

    txg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (line_s),
        .limit  (timeout_cyc),
        .trip   (trip)
    );

    txg_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (line_s),
        .trip   (trip),
        .flag   (to_flag),
        .drv    (tx_out)
    );

    a_r1_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (tx_out && !to_flag) || !rst_n);
endmodule

// File: tb/txg_guard_tb.sv
module txg_guard_tb;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             drv_en = 1'b1;
    logic             drv_val = 1'b1;
    logic [CNT_W-1:0] tmo = 6'd10;
    tri1              tx_pin;
    logic             tx_out, to_flag;

    assign tx_pin = drv_en ? drv_val : 1'bz;

    txg_guard #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_in(tx_pin), .timeout_cyc(tmo),
        .tx_out(tx_out), .to_flag(to_flag)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";
    bit    done   = 0;

    // behavioural reference
    bit     pipe[$];
    integer run;
    bit     m_flag, m_out;

    initial begin
        pipe = '{1'b1, 1'b1}; run = 0; m_flag = 0; m_out = 1;
    end

    always @(posedge clk) begin
        bit cur, pin_v;
        pin_v = drv_en ? drv_val : 1'b1;
        if (!rst_n) begin
            pipe = '{1'b1, 1'b1}; run = 0; m_flag = 0; m_out = 1;
        end else begin
            cur = pipe[0];
            if (cur) m_flag = 0;
            else if (run >= int'(tmo)) m_flag = 1;
            m_out = cur || m_flag;
            run = cur ? 0 : run + 1;
            void'(pipe.pop_front());
            pipe.push_back(pin_v);
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(phase, tx_out,  m_out,  "tx_out");
            check(phase, to_flag, m_flag, "to_flag");
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic low_for(input int n);
        drv_val = 1'b0; cycles(n); drv_val = 1'b1;
    endtask

    initial begin
        cycles(4);
        check("R1", tx_out, 1'b1, "reset tx_out");
        check("R1", to_flag, 1'b0, "reset to_flag");
        rst_n = 1'b1;
        cycles(3);
        check("R1", tx_out, 1'b1, "post-reset tx_out");

        phase = "R2";
        low_for(3); cycles(2); low_for(5); cycles(1); low_for(1); cycles(6);

        phase = "R3";
        drv_val = 1'b0;
        cycles(3);
        check("R3", tx_out, 1'b0, "dominant passes before timeout");
        cycles(11);
        check("R3", to_flag, 1'b1, "flag after timeout");
        phase = "R4";
        cycles(20);
        check("R4", tx_out, 1'b1, "held recessive while low");
        phase = "R5";
        drv_val = 1'b1;
        cycles(3);
        check("R5", to_flag, 1'b0, "flag cleared after high");
        low_for(4); cycles(5);

        phase = "R6";
        low_for(9); cycles(1); low_for(9); cycles(5);
        check("R6", to_flag, 1'b0, "no trip after counter cleared");

        phase = "R7";
        tmo = 6'd63;
        cycles(2);
        drv_val = 1'b0;
        cycles(150);
        check("R7", to_flag, 1'b1, "saturated counter still tripped");
        check("R7", tx_out, 1'b1, "no wrap re-enable");
        drv_val = 1'b1; cycles(5);

        phase = "R8";
        tmo = 6'd0;
        cycles(2);
        low_for(6); cycles(5);
        check("R8", to_flag, 1'b0, "flag cleared after zero-timeout run");

        phase = "R9";
        tmo = 6'd5;
        drv_en = 1'b0;
        cycles(25);
        check("R9", to_flag, 1'b0, "floating pin never trips");
        check("R9", tx_out, 1'b1, "floating pin recessive");
        drv_en = 1'b1;
        cycles(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        done = 1;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule